// File: doc/BRIEF.md
# Legacy Configuration Access Bridge

This block sits on the host side of a peripheral bus and implements the indirect, two-port method of reaching a function's configuration registers. The host I/O side sees two 32-bit ports. One holds a packed address word: an enable bit, bus, device, function and register offset. The other is a data window. Software first loads the address word. It then reads or writes the data window, and the bridge turns that access into one configuration transaction on its downstream channel.

Bus 0 is reached geographically. The device number selects a single high-order address line as a one-hot select, and the low bits carry the function and the dword register number. Any other bus gets a second cycle format, which carries every field in packed form and is marked by a distinct low-bit code. Before the request is raised, the bridge drives the cycle address for a settle interval, so that a slow select line can reach its level. It then waits a bounded number of clocks for a response. If no target answers, the bridge aborts and hands all ones to the host, which is the value software reads as "nothing here".

Top module: `cfg_access_bridge`

## Requirements
- R1: A host write to port `ADDR_PORT` (default 0x0CF8) loads the 32-bit address word. A host read of that port returns the word last written.
- R2: When bit 31 of the address word is 0, no downstream cycle is raised on a data-window access (port `DATA_PORT`, default 0x0CFC). A read returns 0xFFFFFFFF and a write is discarded.
- R3: For bus 0 (word bits [23:16] = 0), `cyc_type1` is 0. The cycle address has bit (device+11) as the only set bit in [31:11], where device is word bits [15:11]. It has the function (word bits [10:8]) in [10:8], word bits [7:2] in [7:2], and 00 in [1:0].
- R4: For a nonzero bus, `cyc_type1` is 1. The cycle address is {8'h00, bus, device, function, word[7:2], 2'b01}.
- R5: With `EXT_EN` = 1, `cyc_ext` carries word bits [27:24] as the upper register-offset nibble for the cycle.
- R6: The cycle address is driven for `SETTLE` clocks before `cyc_valid` rises. It stays stable for as long as `cyc_valid` is high.
- R7: When `cyc_done` is sampled high, the access completes: a read returns `cyc_rdata` to the host. A write presents `cyc_wr` = 1 and the host data on `cyc_wdata`.
- R8: If `cyc_done` is not seen within `TIMEOUT` clocks of `cyc_valid`, the cycle is aborted. `cyc_valid` is high for exactly `TIMEOUT` clocks and the host read returns 0xFFFFFFFF. A response in the last allowed clock still completes normally.
- R9: On bus 0, device numbers above 20 have no select line. The access is aborted at once with no downstream cycle, and a read returns 0xFFFFFFFF.
- R10: A host access to any other I/O address returns 0xFFFFFFFF on a read. A write to such an address changes no state.
- R11: After reset, `io_ack` and `cyc_valid` are low and the address word reads as 0.
- R12: `io_ack` is a single-clock pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host request, held until acknowledged |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O port address |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | One-clock completion pulse |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cyc_valid | output | 1 | Configuration request to the downstream side |
| cyc_type1 | output | 1 | 0 = local geographic cycle, 1 = forwarded cycle |
| cyc_ad | output | 32 | Cycle address word |
| cyc_ext | output | 4 | Upper register-offset nibble |
| cyc_wr | output | 1 | Cycle is a write |
| cyc_wdata | output | 32 | Cycle write data |
| cyc_done | input | 1 | Target response strobe |
| cyc_rdata | input | 32 | Target read data, valid with cyc_done |

## Verification
The bench builds the bridge with `SETTLE` = 3 and `TIMEOUT` = 6 and leaves `EXT_EN` at 1. These short windows make the exact rise time of `cyc_valid` cheap to measure on every forwarded access. They also let the bench reach both the abort after six unanswered clocks and the boundary case, where a target answers in the sixth clock, within a few dozen cycles. Device 20 on bus 0 drives the topmost address line, and device 21 takes the immediate abort path. Together they cover both ends of the select range.

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int          SETTLE    = 4,
  parameter int          TIMEOUT   = 16,
  parameter bit          EXT_EN    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [31:0] io_wdata,
  output logic        io_ack,
  output logic [31:0] io_rdata,
  output logic        cyc_valid,
  output logic        cyc_type1,
  output logic [31:0] cyc_ad,
  output logic [3:0]  cyc_ext,
  output logic        cyc_wr,
  output logic [31:0] cyc_wdata,
  input  logic        cyc_done,
  input  logic [31:0] cyc_rdata
);
  localparam int SEL_BASE = 11;
  localparam int SEL_LINES = 32 - SEL_BASE;
  localparam int CMAX = (SETTLE > TIMEOUT) ? SETTLE : TIMEOUT;
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_WAIT} st_t;
  st_t st;
  logic [31:0] word;
  logic [CW-1:0] cnt;

  logic       en;
  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [5:0] rg;
  assign en  = word[31];
  assign bus = word[23:16];
  assign dev = word[15:11];
  assign fn  = word[10:8];
  assign rg  = word[7:2];

  logic        local_bus, no_slot, take;
  logic [31:0] t0_ad, t1_ad;
  assign local_bus = (bus == 8'd0);
  assign no_slot   = local_bus && (int'(dev) >= SEL_LINES);
  assign t0_ad     = (32'd1 << (6'(dev) + 6'(SEL_BASE))) | {21'd0, fn, rg, 2'b00};
  assign t1_ad     = {8'd0, bus, dev, fn, rg, 2'b01};
  assign take      = io_req && !io_ack && (st == S_IDLE);
  assign cyc_valid = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      word      <= '0;
      cnt       <= '0;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      cyc_type1 <= 1'b0;
      cyc_ad    <= '0;
      cyc_ext   <= '0;
      cyc_wr    <= 1'b0;
      cyc_wdata <= '0;
    end else begin
      io_ack <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (io_addr == ADDR_PORT) begin
            if (io_wr) word <= io_wdata;
            else       io_rdata <= word;
            io_ack <= 1'b1;
          end else if (io_addr == DATA_PORT && en && !no_slot) begin
            cyc_ad    <= local_bus ? t0_ad : t1_ad;
            cyc_type1 <= !local_bus;
            cyc_ext   <= EXT_EN ? word[27:24] : 4'd0;
            cyc_wr    <= io_wr;
            cyc_wdata <= io_wdata;
            cnt       <= '0;
            st        <= S_SETTLE;
          end else begin
            io_rdata <= '1;
            io_ack   <= 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE - 1)) begin
            cnt <= '0;
            st  <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cyc_done) begin
            io_rdata <= cyc_rdata;
            io_ack   <= 1'b1;
            st       <= S_IDLE;
          end else if (cnt == CW'(TIMEOUT - 1)) begin
            io_rdata <= '1;
            io_ack   <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_ad_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $stable(cyc_ad));

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_type1) |-> ($countones(cyc_ad[31:11]) == 1 && cyc_ad[1:0] == 2'b00));

  a_r4_fwd_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type1) |-> (cyc_ad[1:0] == 2'b01));

  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |=> !io_ack);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (take && io_addr == DATA_PORT && !word[31]) |=> (io_ack && !cyc_valid && io_rdata == 32'hFFFF_FFFF));

  a_r9_no_slot_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (take && io_addr == DATA_PORT && word[31] && no_slot) |=> (io_ack && !cyc_valid));
endmodule

// File: tb/cfg_access_bridge_test.sv
module cfg_access_bridge_test;
  localparam int SETTLE  = 3;
  localparam int TIMEOUT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack, cyc_valid, cyc_type1, cyc_wr;
  logic [31:0] io_rdata, cyc_ad, cyc_wdata;
  logic [3:0]  cyc_ext;
  logic        cyc_done = 1'b0;
  logic [31:0] cyc_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int resp_lat = 0;
  int vcnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_access_bridge #(.SETTLE(SETTLE), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata), .cyc_valid(cyc_valid),
    .cyc_type1(cyc_type1), .cyc_ad(cyc_ad), .cyc_ext(cyc_ext), .cyc_wr(cyc_wr),
    .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata));

  // target model: answers resp_lat clocks after the request first appears
  always @(negedge clk) begin
    if (!rst_n || !cyc_valid) begin
      vcnt = 0;
      cyc_done = 1'b0;
    end else begin
      cyc_done = (vcnt == resp_lat);
      vcnt = vcnt + 1;
    end
  end

  typedef struct packed {
    logic [15:0] port;
    logic        wr;
    logic [31:0] wdata;
    logic [7:0]  lat;
    logic [31:0] rdata;
    logic        cyc;
    logic [31:0] ad;
    logic        t1;
    logic [3:0]  ext;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{16'h0CF8, 1'b1, 32'h8000_1A10, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CF8, 1'b0, 32'h0000_0000, 8'd0,  32'h8000_1A10, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd1,  32'h1122_3344, 1'b1, 32'h0000_4210, 1'b0, 4'h0},
    '{16'h0CF8, 1'b1, 32'h8A05_7B44, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b1, 32'h1234_5678, 8'd2,  32'h0000_0000, 1'b1, 32'h0005_7B45, 1'b1, 4'hA},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd99, 32'hFFFF_FFFF, 1'b1, 32'h0005_7B45, 1'b1, 4'hA},
    '{16'h0CF8, 1'b1, 32'h0000_1A10, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd0,  32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b1, 32'hDEAD_BEEF, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CF8, 1'b1, 32'h8000_A800, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd0,  32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CF8, 1'b1, 32'h8000_A000, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd0,  32'hCAFE_F00D, 1'b1, 32'h8000_0000, 1'b0, 4'h0},
    '{16'h0080, 1'b0, 32'h0000_0000, 8'd0,  32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0080, 1'b1, 32'h0000_0000, 8'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CF8, 1'b0, 32'h0000_0000, 8'd0,  32'h8000_A000, 1'b0, 32'h0000_0000, 1'b0, 4'h0},
    '{16'h0CFC, 1'b0, 32'h0000_0000, 8'd5,  32'h0BAD_BEEF, 1'b1, 32'h8000_0000, 1'b0, 4'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, output logic [31:0] got);
    int cyc = 0, first = 0, vc = 0;
    logic [31:0] ad = '0, wd = '0;
    logic t1 = 1'b0, w = 1'b0;
    logic [3:0] ex = '0;
    string tag;
    resp_lat = int'(v.lat);
    cyc_rdata = v.rdata;
    io_addr = v.port; io_wr = v.wr; io_wdata = v.wdata; io_req = 1'b1;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc_valid) begin
        if (first == 0) begin
          first = cyc; ad = cyc_ad; t1 = cyc_type1; ex = cyc_ext; w = cyc_wr; wd = cyc_wdata;
        end
        vc++;
      end
      if (io_ack || cyc > 100) break;
    end
    got = io_rdata;
    io_req = 1'b0;
    chk("R12 ack seen", 32'(io_ack), 32'd1);
    @(negedge clk);
    chk("R12 ack pulse", 32'(io_ack), 32'd0);
    if (v.port == 16'h0CF8)          tag = "R1";
    else if (v.port != 16'h0CFC)     tag = "R10";
    else if (!v.cyc)                 tag = "R2 R9";
    else if (int'(v.lat) >= TIMEOUT) tag = "R8";
    else                             tag = "R7";
    if (!v.wr) chk({tag, " read data"}, got, v.rdata);
    chk({tag, " cycle raised"}, 32'(first != 0), 32'(v.cyc));
    if (v.cyc) begin
      chk(t1 ? "R4 type1 ad" : "R3 type0 ad", ad, v.ad);
      chk("R4 type flag", 32'(t1), 32'(v.t1));
      chk("R5 ext nibble", 32'(ex), 32'(v.ext));
      chk("R6 settle delay", 32'(first), 32'(SETTLE + 1));
      chk("R7 write flag", 32'(w), 32'(v.wr));
      if (v.wr) chk("R7 write data", wd, v.wdata);
      if (int'(v.lat) >= TIMEOUT) chk("R8 abort window", 32'(vc), 32'(TIMEOUT));
      else                        chk("R8 answer window", 32'(vc), 32'(v.lat) + 32'd1);
    end
  endtask

  initial begin
    logic [31:0] got;
    vec_t rd;
    repeat (3) @(negedge clk);
    chk("R11 ack in reset", 32'(io_ack), 32'd0);
    chk("R11 valid in reset", 32'(cyc_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd = '{16'h0CF8, 1'b0, 32'h0, 8'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'h0};
    run_vec(rd, got);
    chk("R11 address word after reset", got, 32'h0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], got);
    // R10: a write to another port leaves the word intact, then a data access uses it
    rd = '{16'h0CF8, 1'b1, 32'h8003_0008, 8'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'h0};
    run_vec(rd, got);
    rd = '{16'h0CFE, 1'b1, 32'h0000_0000, 8'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'h0};
    run_vec(rd, got);
    rd = '{16'h0CFC, 1'b0, 32'h0, 8'd0, 32'h5A5A_A5A5, 1'b1, 32'h0003_0009, 1'b1, 4'h0};
    run_vec(rd, got);
    // R3: device 0 on bus 0, top register number
    rd = '{16'h0CF8, 1'b1, 32'h8000_07FF, 8'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'h0};
    run_vec(rd, got);
    rd = '{16'h0CFC, 1'b0, 32'h0, 8'd3, 32'h0000_0001, 1'b1, 32'h0000_0FFC, 1'b0, 4'h0};
    run_vec(rd, got);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule